// File: doc/BRIEF.md
# Audio Serial Clock Divider with Enable Guard

This block derives a slow audio serial clock from a faster parent clock. The parent clock arrives as a one-cycle reference tick (`tick_i`) in the system clock domain. A programmable integer counter divides that tick stream. The block produces two outputs: a square-wave level (`div_clk_o`) and a one-cycle strobe (`div_stb_o`) that marks the end of each output period. Downstream logic can use the strobe as a clock enable.

Software controls the block through a single 32-bit word, written and read through a simple register port. The divide ratio and the enable bits live in the same word. The output runs only when both enable bits are set and the stored ratio is at least 2. A ratio of 0 or 1 yields no output. Writing enable with such a ratio raises an error flag.

To disable the divider, write zero to the whole word. A new ratio written while the divider runs takes effect at the next period boundary, so the output never produces a runt pulse.

Top module: `adiv_clk_gen`

## Requirements
- R1: While reset is asserted and after its release, the read data is zero, `div_clk_o`, `div_stb_o` and `err_o` are low.
- R2: A write stores bits 31:16 of the write data as an unsigned 16-bit divide ratio and bits 1:0 as the enable field. Reads return those two fields in the same positions, with every other bit zero, from the cycle after the write.
- R3: The outputs are active only while the enable field holds 2'b11 and the stored ratio is 2 or more. Otherwise `div_clk_o` and `div_stb_o` are low from the cycle after the write, including for enable values 2'b01 and 2'b10.
- R4: When the block turns active, the period counter restarts from zero. The output is low in the cycle after the enabling write, and the first high cycle follows on the next edge. This also holds after a stop in mid-period.
- R5: An active output with ratio N repeats every N ticks. It is high for floor(N/2) ticks and low for the remaining ticks, so odd ratios give the shorter high phase. This covers ratios from 2 up to 65535.
- R6: `div_stb_o` is high for exactly one cycle per period: the cycle in which the tick arrives on the last count of the period. It is never high while `div_clk_o` is high.
- R7: The counter advances only in cycles where `tick_i` is high. Without ticks, `div_clk_o` holds its level and `div_stb_o` stays low.
- R8: A ratio written while the block stays active takes effect only from the next period boundary. The current period finishes with the old ratio.
- R9: Every write updates `err_o`. It is set when the written enable field is 2'b11 and the written ratio is below 2, and cleared by any other write.
- R10: Writing a ratio with enable field 2'b00 leaves the output stopped. A later write with enable 2'b11 starts it.
- R11: Writing zero stops the output in the cycle after the write and clears both the ratio and the enable fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-cycle reference tick from the parent clock |
| wr_en_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 32 | Control word write data |
| rdata_o | output | 32 | Control word read data (ratio and enable fields) |
| div_clk_o | output | 1 | Divided square-wave output level |
| div_stb_o | output | 1 | One-cycle strobe on the last tick of each output period |
| err_o | output | 1 | Set by a write that enables with a ratio below 2 |

## Verification
A write is captured on the clock edge where `wr_en_i` is high. The read data and `err_o` change on that same edge, and the guard lowers the outputs on it as well. The bench therefore samples these values at the falling edge that follows. A start takes one further edge to load the counter, so the bench expects a low output at that first sample and phase zero one cycle later. After that, every tick moves the counter by one position on the next edge. The bench drives stimuli at falling edges and compares each falling-edge sample against the phase it computes from the ratio.

// File: rtl/adiv_pkg.sv
package adiv_pkg;
  localparam int unsigned CTRL_W    = 32;
  localparam int unsigned RATIO_W   = 16;
  localparam int unsigned RATIO_LSB = 16;
  localparam int unsigned EN_W      = 2;
  localparam int unsigned MIN_RATIO = 2;
endpackage

// File: rtl/adiv_rst_sync.sv
module adiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/adiv_ctrl_reg.sv
module adiv_ctrl_reg
  import adiv_pkg::*;
#(
  parameter int unsigned REG_W = CTRL_W,
  parameter int unsigned RW    = RATIO_W,
  parameter int unsigned RLSB  = RATIO_LSB,
  parameter int unsigned EW    = EN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [RW-1:0]    ratio_o,
  output logic [EW-1:0]    en_o,
  output logic             run_o,
  output logic             err_o
);
  localparam logic [RW-1:0] MIN_R = RW'(MIN_RATIO);

  logic [RW-1:0] ratio_q, ratio_d;
  logic [EW-1:0] en_q, en_d;
  logic          err_q, err_d;
  logic          unused_wbits;

  assign unused_wbits = ^wdata_i;

  // next state, used only on a write cycle
  always_comb begin
    ratio_d = wdata_i[RLSB +: RW];
    en_d    = wdata_i[EW-1:0];
    err_d   = (en_d == {EW{1'b1}}) && (ratio_d < MIN_R);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      en_q    <= '0;
      err_q   <= 1'b0;
    end else if (wr_i) begin
      ratio_q <= ratio_d;
      en_q    <= en_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    rdata_o              = '0;
    rdata_o[RLSB +: RW]  = ratio_q;
    rdata_o[EW-1:0]      = en_q;
  end

  assign ratio_o = ratio_q;
  assign en_o    = en_q;
  assign err_o   = err_q;
  assign run_o   = (en_q == {EW{1'b1}}) && (ratio_q >= MIN_R);

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (wdata_i[EW-1:0] == {EW{1'b1}}) && (wdata_i[RLSB +: RW] < MIN_R)) |=> err_o);
  // R9
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(err_o));
  // R2
  rdata_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(rdata_o));
endmodule

// File: rtl/adiv_core.sv
module adiv_core
  import adiv_pkg::*;
#(
  parameter int unsigned RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [RW-1:0] ratio_i,
  input  logic          tick_i,
  output logic          clk_o,
  output logic          stb_o
);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic          run_q, run_d;
  logic [RW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] act_q, act_d;
  logic          cnt_en;
  logic          start, adv, last;
  logic [RW-1:0] half;

  assign start = run_i & ~run_q;
  assign adv   = run_i & run_q & tick_i;
  assign last  = (cnt_q == (act_q - ONE));
  assign half  = act_q >> 1;

  always_comb begin
    run_d  = run_i;
    cnt_d  = cnt_q;
    act_d  = act_q;
    cnt_en = 1'b0;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      act_d  = ratio_i;
    end else if (adv) begin
      cnt_en = 1'b1;
      if (last) begin
        cnt_d = '0;
        act_d = ratio_i;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign clk_o = run_i & run_q & (cnt_q < half);
  assign stb_o = adv & last;

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ((cnt_q < act_q) && (act_q >= RW'(MIN_RATIO))));
  // R6
  stb_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> (tick_i && !clk_o));
  // R7
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run_i && !tick_i) |=> $stable(cnt_q));
  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run_i && !(tick_i && last)) |=> $stable(act_q));
  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !run_q) |=> (cnt_q == '0));
endmodule

// File: rtl/adiv_clk_gen.sv
module adiv_clk_gen
  import adiv_pkg::*;
#(
  parameter int unsigned REG_W = CTRL_W,
  parameter int unsigned RW    = RATIO_W,
  parameter int unsigned RLSB  = RATIO_LSB,
  parameter int unsigned EW    = EN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             div_clk_o,
  output logic             div_stb_o,
  output logic             err_o
);
  logic          rst_sync_n;
  logic [RW-1:0] ratio;
  logic [EW-1:0] en;
  logic          run;

  adiv_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adiv_ctrl_reg #(.REG_W(REG_W), .RW(RW), .RLSB(RLSB), .EW(EW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (wr_en_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ratio_o (ratio),
    .en_o    (en),
    .run_o   (run),
    .err_o   (err_o)
  );

  adiv_core #(.RW(RW)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (run),
    .ratio_i (ratio),
    .tick_i  (tick_i),
    .clk_o   (div_clk_o),
    .stb_o   (div_stb_o)
  );

  // R3
  guard_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (div_clk_o || div_stb_o) |-> ((en == {EW{1'b1}}) && (ratio >= RW'(MIN_RATIO))));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!div_clk_o && !div_stb_o && !err_o));
endmodule

// File: tb/test_adiv_clk_gen.sv
`timescale 1ns/1ps
module test_adiv_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        div_clk, div_stb, err;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  adiv_clk_gen i_adiv_clk_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .div_clk_o (div_clk),
    .div_stb_o (div_stb),
    .err_o     (err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capture edge
  task automatic wr(logic [31:0] d);
    wr_en = 1'b1;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    wdata = '0;
  endtask

  task automatic check_wave(int r, int ph, int n, string req);
    for (int i = 0; i < n; i++) begin
      int p;
      @(negedge clk);
      p = (ph + i) % r;
      chk(req, {31'd0, div_clk}, {31'd0, (p < r / 2)});
      chk(req, {31'd0, div_stb}, {31'd0, (p == r - 1)});
    end
  endtask

  task automatic start(int r);
    wr(32'd0);
    wr({16'(r), 16'h0003});
    chk("R4 first cycle low", {31'd0, div_clk}, 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 32'd0);
    chk("R1 clk in reset", {31'd0, div_clk}, 32'd0);
    chk("R1 err in reset", {31'd0, err}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdata after reset", rdata, 32'd0);
    chk("R1 stb after reset", {31'd0, div_stb}, 32'd0);
    chk("R1 err after reset", {31'd0, err}, 32'd0);
    tick = 1'b1;
  endtask

  task automatic t_even;
    start(4);
    check_wave(4, 0, 12, "R5 R6 ratio4");
  endtask

  task automatic t_odd;
    start(5);
    check_wave(5, 0, 15, "R5 ratio5");
    start(3);
    check_wave(3, 0, 9, "R5 ratio3");
    start(2);
    check_wave(2, 0, 8, "R5 ratio2");
  endtask

  task automatic t_change;
    start(4);
    check_wave(4, 0, 8, "R8 before change");
    wr({16'd6, 16'h0003});
    chk("R8 old period continues", {31'd0, div_clk}, 32'd1);
    check_wave(4, 1, 3, "R8 old ratio to boundary");
    check_wave(6, 0, 12, "R8 new ratio");
  endtask

  task automatic t_tick_hold;
    start(6);
    check_wave(6, 0, 6, "R7 before hold");
    tick = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 hold clk", {31'd0, div_clk}, 32'd0);
      chk("R7 hold stb", {31'd0, div_stb}, 32'd0);
    end
    tick = 1'b1;
    check_wave(6, 0, 8, "R7 resume");
  endtask

  task automatic t_guard;
    wr(32'd0);
    wr({16'd5, 16'h0000});
    chk("R10 ratio stored", rdata, 32'h0005_0000);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R10 stopped without enable", {31'd0, div_clk}, 32'd0);
    end
    wr({16'd4, 16'h0001});
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R3 partial enable 01", {31'd0, div_clk | div_stb}, 32'd0);
    end
    chk("R3 partial enable no err", {31'd0, err}, 32'd0);
    wr({16'd5, 16'h0003});
    chk("R10 first cycle low", {31'd0, div_clk}, 32'd0);
    check_wave(5, 0, 10, "R10 started");
  endtask

  task automatic t_restart;
    start(4);
    check_wave(4, 0, 3, "R4 before stop");
    wr({16'd4, 16'h0000});
    chk("R4 stopped mid period", {31'd0, div_clk}, 32'd0);
    wr({16'd4, 16'h0003});
    chk("R4 restart first low", {31'd0, div_clk}, 32'd0);
    check_wave(4, 0, 4, "R4 counter restarted");
  endtask

  task automatic t_error;
    wr(32'd0);
    wr({16'd1, 16'h0003});
    chk("R9 err ratio1", {31'd0, err}, 32'd1);
    chk("R2 readback ratio1", rdata, 32'h0001_0003);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R3 ratio1 idle", {31'd0, div_clk | div_stb}, 32'd0);
    end
    wr(32'd0);
    chk("R9 cleared by zero write", {31'd0, err}, 32'd0);
    wr(32'h0000_0003);
    chk("R9 err ratio0", {31'd0, err}, 32'd1);
    @(negedge clk);
    chk("R3 ratio0 idle", {31'd0, div_clk}, 32'd0);
    wr({16'd2, 16'h0003});
    chk("R9 cleared by valid write", {31'd0, err}, 32'd0);
    chk("R4 first cycle low", {31'd0, div_clk}, 32'd0);
    check_wave(2, 0, 6, "R9 valid after error");
  endtask

  task automatic t_layout;
    wr(32'd0);
    wr(32'hFFFF_FFFF);
    chk("R2 readback max", rdata, 32'hFFFF_0003);
    check_wave(65535, 0, 10, "R5 ratio65535");
    wr(32'h1234_5678);
    chk("R2 readback fields", rdata, 32'h1234_0000);
    chk("R3 stopped by enable 00", {31'd0, div_clk}, 32'd0);
  endtask

  task automatic t_disable;
    start(4);
    check_wave(4, 0, 5, "R11 before disable");
    wr(32'd0);
    chk("R11 rdata cleared", rdata, 32'd0);
    for (int i = 0; i < 4; i++) begin
      chk("R11 output stopped", {31'd0, div_clk | div_stb}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    tick  = 1'b0;
    wr_en = 1'b0;
    wdata = '0;
    @(negedge clk);
    t_reset();
    t_even();
    t_odd();
    t_change();
    t_tick_hold();
    t_guard();
    t_restart();
    t_error();
    t_layout();
    t_disable();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule